// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects interrupt events from a configurable number of sources, 64 by default. It presents the single most urgent one to a processor. A rising edge on a source input latches a flag bit, and the flag stays set until software clears it. An enable bit per source decides whether that flag takes part in arbitration. Each source also carries a 3-bit level and a 2-bit sub-level. Among the pending sources, the highest level wins. The sub-level decides between equal levels, and the lowest source number decides a full tie.

The processor supplies its current level. The block raises its request only when the winning level is strictly above that level. The winner's number and level are registered outputs. The block also holds one mode bit that chooses between one common vector and per-source vectors. Vector address generation itself is left to the surrounding logic.

Software reaches every register over a simple synchronous bus. Reads are combinational from the address. A write acts on the clock edge. The two low address bits pick how a write is applied: plain write, write-one-to-set, write-one-to-clear, or no effect.

Top module: `pvic_top`

## Requirements
- R1: The bus address is {kind[1:0], index[3:0], op[1:0]}. Kind is 0 for flags, 1 for enables, 2 for levels and 3 for control. Flags and enables pack 32 sources per register: source n sits at index n>>5, bit n mod 32. Indexes beyond the last register read as zero and ignore writes.
- R2: op 0 replaces the register with the written data. op 1 sets only the bits written as 1, and op 2 clears only the bits written as 1. op 3 changes nothing. A read returns the register content whatever op is given.
- R3: A source input seen low and then high on consecutive clocks sets its flag. A steady high input does not set the flag again after software clears it. A flag stays set until it is cleared. A hardware edge in the same cycle as a software clear leaves the flag set.
- R4: A source is pending only when its flag and its enable are both 1. A flagged source that is not enabled is never reported.
- R5: Level register k holds sources 4k to 4k+3, one byte each, with source n in byte n mod 4. In each byte, bits [4:2] hold the level and bits [1:0] hold the sub-level. Bits [7:5] read as zero.
- R6: The winner is the pending source with the highest level. Equal levels are decided by the higher sub-level, and then by the lower source number. A source with level 0 never wins.
- R7: irq_req is 1 only when the winning level is strictly greater than cpu_level.
- R8: win_id, win_level and irq_req are registered, so they follow a change of state or cpu_level one clock later. With nothing eligible, all three are zero.
- R9: Control register bit 0 selects per-source vectors. single_vec is 1 while that bit is 0. The other control bits read as zero.
- R10: Synchronous reset clears all flags, enables, levels, the mode bit and the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NUM_SRC | Source event inputs, edge-detected |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | {kind, index, op} address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| cpu_level | input | 3 | Processor's current level |
| irq_req | output | 1 | Request to the processor |
| win_id | output | SRC_W | Number of the winning source |
| win_level | output | 3 | Level of the winning source, 0 if none |
| single_vec | output | 1 | 1 when all interrupts use one common vector |

## Verification
The bench builds the block with its 64-source default. That default gives two flag and enable registers and sixteen level registers. Sources 37 and 60 sit in the second flag register, and sources 2, 5, 36 and 37 share byte lanes with their neighbours. This exercises the index and bit decode across a register boundary, masking of the unused byte bits, and ties decided first by sub-level and then by source number.

// File: rtl/pvic_pkg.sv
package pvic_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLEAR = 2'd2,
        OP_NONE  = 2'd3
    } bus_op_e;

    typedef enum logic [1:0] {
        RK_FLAG   = 2'd0,
        RK_ENABLE = 2'd1,
        RK_LEVEL  = 2'd2,
        RK_CTRL   = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic [2:0] level;
        logic [1:0] sub;
    } prio_t;

    localparam int WORD_W    = 32;
    localparam int LANE_W    = 8;
    localparam int PRIO_W    = 5;
    localparam int LANES     = WORD_W / LANE_W;

    // Combine the current register word with a bus write according to op.
    function automatic logic [WORD_W-1:0] apply_op(input logic [WORD_W-1:0] cur,
                                                   input logic [WORD_W-1:0] wdata,
                                                   input bus_op_e op);
        logic [WORD_W-1:0] res;
        case (op)
            OP_WRITE: res = wdata;
            OP_SET:   res = cur | wdata;
            OP_CLEAR: res = cur & ~wdata;
            default:  res = cur;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/pvic_bit_bank.sv
module pvic_bit_bank
    import pvic_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int IDX_W   = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     idx,
    input  bus_op_e              op,
    input  logic [WORD_W-1:0]    wdata,
    input  logic [NUM_SRC-1:0]   hw_set,
    output logic [NUM_SRC-1:0]   bits,
    output logic [WORD_W-1:0]    rd_word
);
    localparam int NREG = (NUM_SRC + WORD_W - 1) / WORD_W;
    localparam int PADW = NREG * WORD_W;

    logic [NUM_SRC-1:0] bits_q, bits_d;
    logic [PADW-1:0]    pad_cur, pad_new;
    logic               idx_ok;

    assign pad_cur = PADW'(bits_q);
    assign idx_ok  = (int'(idx) < NREG);
    assign rd_word = idx_ok ? pad_cur[int'(idx)*WORD_W +: WORD_W] : '0;

    // Software update first, hardware events OR-ed on top so they win.
    always_comb begin
        pad_new = pad_cur;
        if (wr_en && idx_ok) begin
            pad_new[int'(idx)*WORD_W +: WORD_W] =
                apply_op(pad_cur[int'(idx)*WORD_W +: WORD_W], wdata, op);
        end
        bits_d = pad_new[NUM_SRC-1:0] | hw_set;
    end

    always_ff @(posedge clk) begin
        if (rst) bits_q <= '0;
        else     bits_q <= bits_d;
    end

    assign bits = bits_q;
endmodule

// File: rtl/pvic_level_bank.sv
module pvic_level_bank
    import pvic_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int IDX_W   = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          idx,
    input  bus_op_e                   op,
    input  logic [WORD_W-1:0]         wdata,
    output logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output logic [WORD_W-1:0]         rd_word
);
    localparam int NREG  = (NUM_SRC + LANES - 1) / LANES;
    localparam int PADW  = NREG * WORD_W;
    localparam int SLOTS = NREG * LANES;

    logic [PADW-1:0]   pad_cur;
    logic [WORD_W-1:0] new_word;
    logic              idx_ok;
    logic              unused_lane_bits;

    assign idx_ok   = (int'(idx) < NREG);
    assign rd_word  = idx_ok ? pad_cur[int'(idx)*WORD_W +: WORD_W] : '0;
    assign new_word = apply_op(rd_word, wdata, op);
    assign unused_lane_bits = ^new_word;

    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_lane
            if (s < NUM_SRC) begin : g_real
                prio_t fld_q;
                always_ff @(posedge clk) begin
                    if (rst) begin
                        fld_q <= '0;
                    end else if (wr_en && idx_ok && int'(idx) == s / LANES) begin
                        fld_q <= prio_t'(new_word[(s % LANES)*LANE_W +: PRIO_W]);
                    end
                end
                assign prio_flat[s*PRIO_W +: PRIO_W] = fld_q;
                assign pad_cur[s*LANE_W +: LANE_W]  = {3'b000, fld_q};
            end else begin : g_pad
                assign pad_cur[s*LANE_W +: LANE_W] = '0;
            end
        end
    endgenerate
endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter
    import pvic_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int SRC_W   = 6
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_SRC-1:0]        pend,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    input  logic [2:0]                cpu_level,
    output logic [SRC_W-1:0]          win_id,
    output logic [2:0]                win_level,
    output logic                      irq_req
);
    logic [PRIO_W-1:0] best_key;
    logic [SRC_W-1:0]  best_id;
    prio_t             cand;

    // Ascending scan with strict compare keeps the lowest index on a full tie.
    always_comb begin
        best_key = '0;
        best_id  = '0;
        cand     = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            cand = prio_t'(prio_flat[i*PRIO_W +: PRIO_W]);
            if (pend[i] && cand.level != 3'd0 && {cand.level, cand.sub} > best_key) begin
                best_key = {cand.level, cand.sub};
                best_id  = SRC_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_id    <= '0;
            win_level <= '0;
            irq_req   <= 1'b0;
        end else begin
            win_id    <= best_id;
            win_level <= best_key[4:2];
            irq_req   <= (best_key[4:2] > cpu_level);
        end
    end
endmodule

// File: rtl/pvic_top.sv
module pvic_top
    import pvic_pkg::*;
#(
    parameter int  NUM_SRC = 64,
    localparam int NLREG   = (NUM_SRC + 3) / 4,
    localparam int IDX_W   = (NLREG > 1) ? $clog2(NLREG) : 1,
    localparam int ADDR_W  = IDX_W + 4,
    localparam int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [2:0]         cpu_level,
    output logic               irq_req,
    output logic [SRC_W-1:0]   win_id,
    output logic [2:0]         win_level,
    output logic               single_vec
);
    reg_kind_e          kind;
    bus_op_e            op;
    logic [IDX_W-1:0]   idx;
    logic [NUM_SRC-1:0] src_q, src_rise, flag_bits, en_bits, pend_vec;
    logic [31:0]        flag_word, en_word, lvl_word;
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic               mvec_q, mvec_d, ctrl_hit;

    assign kind     = reg_kind_e'(bus_addr[ADDR_W-1 -: 2]);
    assign op       = bus_op_e'(bus_addr[1:0]);
    assign idx      = bus_addr[2 +: IDX_W];
    assign src_rise = src_in & ~src_q;
    assign pend_vec = flag_bits & en_bits;
    assign ctrl_hit = (kind == RK_CTRL) && (idx == '0);

    always_ff @(posedge clk) begin
        if (rst) src_q <= '0;
        else     src_q <= src_in;
    end

    pvic_bit_bank #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_flags (
        .clk(clk), .rst(rst), .wr_en(bus_wr && kind == RK_FLAG), .idx(idx), .op(op),
        .wdata(bus_wdata), .hw_set(src_rise), .bits(flag_bits), .rd_word(flag_word));

    pvic_bit_bank #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_enables (
        .clk(clk), .rst(rst), .wr_en(bus_wr && kind == RK_ENABLE), .idx(idx), .op(op),
        .wdata(bus_wdata), .hw_set('0), .bits(en_bits), .rd_word(en_word));

    pvic_level_bank #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_levels (
        .clk(clk), .rst(rst), .wr_en(bus_wr && kind == RK_LEVEL), .idx(idx), .op(op),
        .wdata(bus_wdata), .prio_flat(prio_flat), .rd_word(lvl_word));

    pvic_arbiter #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_arb (
        .clk(clk), .rst(rst), .pend(pend_vec), .prio_flat(prio_flat), .cpu_level(cpu_level),
        .win_id(win_id), .win_level(win_level), .irq_req(irq_req));

    // Mode bit: only bit 0 of the control word exists.
    always_comb begin
        mvec_d = mvec_q;
        if (bus_wr && ctrl_hit) begin
            case (op)
                OP_WRITE: mvec_d = bus_wdata[0];
                OP_SET:   mvec_d = mvec_q | bus_wdata[0];
                OP_CLEAR: mvec_d = mvec_q & ~bus_wdata[0];
                default:  mvec_d = mvec_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mvec_q <= 1'b0;
        else     mvec_q <= mvec_d;
    end

    assign single_vec = ~mvec_q;

    always_comb begin
        case (kind)
            RK_FLAG:   bus_rdata = flag_word;
            RK_ENABLE: bus_rdata = en_word;
            RK_LEVEL:  bus_rdata = lvl_word;
            default:   bus_rdata = ctrl_hit ? {31'b0, mvec_q} : 32'b0;
        endcase
    end
endmodule

// File: rtl/pvic_checker.sv
module pvic_checker #(
    parameter int NUM_SRC = 64,
    parameter int ADDR_W  = 8,
    parameter int SRC_W   = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_wdata,
    input logic [2:0]         cpu_level,
    input logic               irq_req,
    input logic [SRC_W-1:0]   win_id,
    input logic [2:0]         win_level,
    input logic               single_vec,
    input logic [NUM_SRC-1:0] pend_vec
);
    logic [NUM_SRC-1:0] pend_prev;
    logic               ctrl0_wr;

    always_ff @(posedge clk) begin
        if (rst) pend_prev <= '0;
        else     pend_prev <= pend_vec;
    end

    assign ctrl0_wr = bus_wr && bus_addr[ADDR_W-1 -: 2] == 2'b11 && bus_addr[ADDR_W-3:2] == '0;

    // R4: a reported winner was pending in the cycle it was chosen from
    assert_winner_pending_R4: assert property (@(posedge clk) disable iff (rst)
        (win_level != 3'd0) |-> pend_prev[win_id]);

    // R7: request only above the processor level seen one clock earlier
    assert_req_above_level_R7: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (win_level > $past(cpu_level)));

    // R8: no winner means idle outputs
    assert_idle_outputs_R8: assert property (@(posedge clk) disable iff (rst)
        (win_level == 3'd0) |-> (win_id == '0 && !irq_req));

    // R9: set alias on the mode bit leaves common-vector mode
    assert_mode_set_R9: assert property (@(posedge clk) disable iff (rst)
        (ctrl0_wr && bus_addr[1:0] == 2'b01 && bus_wdata[0]) |=> !single_vec);

    // R9: clear alias on the mode bit returns to common-vector mode
    assert_mode_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (ctrl0_wr && bus_addr[1:0] == 2'b10 && bus_wdata[0]) |=> single_vec);
endmodule

bind pvic_top pvic_checker #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .SRC_W(SRC_W)) chk_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .cpu_level(cpu_level), .irq_req(irq_req), .win_id(win_id), .win_level(win_level),
    .single_vec(single_vec), .pend_vec(pend_vec));

// File: tb/pvic_top_tb_top.sv
module pvic_top_tb_top;
    localparam int N = 64;
    localparam logic [1:0] K_FLAG = 2'd0, K_EN = 2'd1, K_LVL = 2'd2, K_CTRL = 2'd3;
    localparam logic [1:0] O_WR = 2'd0, O_SET = 2'd1, O_CLR = 2'd2, O_NONE = 2'd3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst;
    logic [N-1:0]  src_in;
    logic          bus_wr;
    logic [7:0]    bus_addr;
    logic [31:0]   bus_wdata, bus_rdata;
    logic [2:0]    cpu_level;
    logic          irq_req, single_vec;
    logic [5:0]    win_id;
    logic [2:0]    win_level;

    pvic_top #(.NUM_SRC(N)) dut_i (
        .clk(clk), .rst(rst), .src_in(src_in), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_level(cpu_level),
        .irq_req(irq_req), .win_id(win_id), .win_level(win_level), .single_vec(single_vec));

    int checks = 0, errors = 0;
    bit m_flag[N], m_en[N], m_prev[N], m_mvec;
    int m_lvl[N], m_sub[N];
    int e_id = 0, e_lvl = 0;
    bit e_req = 0;

    task automatic chk_eq(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [1:0] kind, input int idx);
        logic [31:0] w = '0;
        case (kind)
            K_FLAG, K_EN:
                if (idx < 2) for (int b = 0; b < 32; b++)
                    w[b] = (kind == K_FLAG) ? m_flag[idx*32+b] : m_en[idx*32+b];
            K_LVL:
                for (int j = 0; j < 4; j++)
                    w[j*8 +: 8] = 8'((m_lvl[idx*4+j] << 2) | m_sub[idx*4+j]);
            default: w = (idx == 0) ? {31'b0, m_mvec} : 32'b0;
        endcase
        return w;
    endfunction

    task automatic m_write(input logic [1:0] kind, input int idx, input logic [1:0] op,
                           input logic [31:0] d);
        logic [31:0] cur = m_read(kind, idx);
        logic [31:0] nw;
        case (op)
            O_WR:    nw = d;
            O_SET:   nw = cur | d;
            O_CLR:   nw = cur & ~d;
            default: nw = cur;
        endcase
        case (kind)
            K_FLAG, K_EN:
                if (idx < 2) for (int b = 0; b < 32; b++)
                    if (kind == K_FLAG) m_flag[idx*32+b] = nw[b]; else m_en[idx*32+b] = nw[b];
            K_LVL:
                for (int j = 0; j < 4; j++) begin
                    m_lvl[idx*4+j] = int'(nw[j*8+2 +: 3]);
                    m_sub[idx*4+j] = int'(nw[j*8 +: 2]);
                end
            default: if (idx == 0) m_mvec = nw[0];
        endcase
    endtask

    // One clock: predict registered outputs from pre-edge state, update model, compare.
    task automatic step();
        int bl = 0, bs = -1, bi = 0;
        bit found = 0;
        for (int i = 0; i < N; i++)
            if (m_flag[i] && m_en[i] && m_lvl[i] > bl) bl = m_lvl[i];
        if (bl > 0) begin
            for (int i = 0; i < N; i++)
                if (m_flag[i] && m_en[i] && m_lvl[i] == bl && m_sub[i] > bs) bs = m_sub[i];
            for (int i = 0; i < N; i++)
                if (!found && m_flag[i] && m_en[i] && m_lvl[i] == bl && m_sub[i] == bs) begin
                    bi = i;
                    found = 1;
                end
        end
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_flag[i] = 0; m_en[i] = 0; m_lvl[i] = 0; m_sub[i] = 0; m_prev[i] = 0;
            end
            m_mvec = 0;
            bl = 0; bi = 0;
        end else begin
            if (bus_wr) m_write(bus_addr[7:6], int'(bus_addr[5:2]), bus_addr[1:0], bus_wdata);
            for (int i = 0; i < N; i++) begin
                if (src_in[i] && !m_prev[i]) m_flag[i] = 1;
                m_prev[i] = src_in[i];
            end
        end
        e_req = !rst && (bl > int'(cpu_level));
        e_lvl = bl;
        e_id  = bi;
        @(posedge clk);
        @(negedge clk);
        chk_eq("R6 cycle winner number", win_id, e_id);
        chk_eq("R6 cycle winner level", win_level, e_lvl);
        chk_eq("R7 cycle request", irq_req, e_req);
        chk_eq("R9 cycle vector mode", single_vec, !m_mvec);
    endtask

    task automatic bus_write(input logic [1:0] kind, input logic [3:0] idx, input logic [1:0] op,
                             input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = {kind, idx, op}; bus_wdata = d;
        step();
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic read_chk(input string tag, input logic [1:0] kind, input logic [3:0] idx,
                            input logic [1:0] op, input logic [31:0] exp);
        bus_addr = {kind, idx, op};
        #1;
        chk_eq(tag, bus_rdata, exp);
        chk_eq({tag, " model"}, bus_rdata, m_read(kind, int'(idx)));
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; src_in = '0; bus_wr = 0; bus_addr = '0; bus_wdata = '0; cpu_level = '0;
        repeat (3) step();
        rst = 0;
        step();
        // R10: everything cleared
        chk_eq("R10 reset win_level", win_level, 0);
        chk_eq("R10 reset irq_req", irq_req, 0);
        chk_eq("R10 reset single_vec", single_vec, 1);
        read_chk("R10 flag reg 1", K_FLAG, 4'd1, O_WR, 32'h0);
        read_chk("R10 enable reg 0", K_EN, 4'd0, O_WR, 32'h0);
        read_chk("R10 level reg 9", K_LVL, 4'd9, O_WR, 32'h0);
        read_chk("R10 control", K_CTRL, 4'd0, O_WR, 32'h0);

        // R1 R3: edge on source 37 lands in register 1 bit 5
        src_in[37] = 1'b1; step(); src_in[37] = 1'b0; step();
        read_chk("R1 flag reg 1 bit 5", K_FLAG, 4'd1, O_SET, 32'h0000_0020);
        read_chk("R1 flag reg 0 untouched", K_FLAG, 4'd0, O_WR, 32'h0);
        chk_eq("R4 flagged but disabled", win_level, 0);

        bus_write(K_EN, 4'd1, O_SET, 32'h0000_0020);
        bus_write(K_LVL, 4'd9, O_SET, 32'h0000_0D00);
        chk_eq("R8 winner not yet visible", win_level, 0);
        step();
        chk_eq("R8 winner one clock later", win_level, 3);
        chk_eq("R6 winner is 37", win_id, 37);
        chk_eq("R7 level 3 over cpu 0", irq_req, 1);
        cpu_level = 3'd2; step();
        chk_eq("R7 level 3 over cpu 2", irq_req, 1);
        cpu_level = 3'd3; step();
        chk_eq("R7 equal level not taken", irq_req, 0);
        cpu_level = 3'd0; step();

        // R5: byte lanes and masked upper bits
        bus_write(K_LVL, 4'd9, O_WR, 32'hFFE3_0DF2);
        read_chk("R5 lane layout", K_LVL, 4'd9, O_WR, 32'h1F03_0D12);
        bus_write(K_LVL, 4'd9, O_WR, 32'h0000_0D00);

        // R6: sub-level then number breaks ties
        bus_write(K_FLAG, 4'd0, O_SET, 32'h0000_0024);
        bus_write(K_EN, 4'd0, O_SET, 32'h0000_0020);
        bus_write(K_LVL, 4'd1, O_SET, 32'h0000_0E00);
        step();
        chk_eq("R6 higher sub-level wins", win_id, 5);
        bus_write(K_EN, 4'd0, O_SET, 32'h0000_0004);
        bus_write(K_LVL, 4'd0, O_SET, 32'h000E_0000);
        step();
        chk_eq("R6 lowest number wins full tie", win_id, 2);
        bus_write(K_EN, 4'd1, O_SET, 32'h1000_0000);
        bus_write(K_LVL, 4'd15, O_SET, 32'h0000_0014);
        src_in[60] = 1'b1; step(); src_in[60] = 1'b0; step(); step();
        chk_eq("R6 highest level wins", win_id, 60);
        chk_eq("R6 highest level value", win_level, 5);
        bus_write(K_LVL, 4'd15, O_CLR, 32'h0000_001F);
        step();
        chk_eq("R6 level 0 never wins", win_id, 2);

        // R4: disabling removes the source
        bus_write(K_EN, 4'd0, O_CLR, 32'h0000_0004);
        step();
        chk_eq("R4 disabled source dropped", win_id, 5);

        // R3: held input does not re-flag; edge beats a same-cycle clear
        src_in[5] = 1'b1; step(); step();
        bus_write(K_FLAG, 4'd0, O_CLR, 32'h0000_0020);
        step();
        read_chk("R3 held input no re-flag", K_FLAG, 4'd0, O_WR, 32'h0000_0004);
        src_in[5] = 1'b0; step();
        src_in[2] = 1'b1;
        bus_write(K_FLAG, 4'd0, O_CLR, 32'h0000_0004);
        src_in[2] = 1'b0;
        read_chk("R3 edge beats clear", K_FLAG, 4'd0, O_WR, 32'h0000_0004);

        // R2: op 3 ignored, op 0 replaces
        bus_write(K_FLAG, 4'd0, O_NONE, 32'hFFFF_FFFF);
        read_chk("R2 reserved op no effect", K_FLAG, 4'd0, O_NONE, 32'h0000_0004);
        bus_write(K_FLAG, 4'd0, O_WR, 32'h0000_0101);
        read_chk("R2 plain write replaces", K_FLAG, 4'd0, O_CLR, 32'h0000_0101);

        // R9: mode bit
        bus_write(K_CTRL, 4'd0, O_SET, 32'hFFFF_FFFF);
        chk_eq("R9 per-source vectors", single_vec, 0);
        read_chk("R9 only bit 0 exists", K_CTRL, 4'd0, O_WR, 32'h0000_0001);
        bus_write(K_CTRL, 4'd0, O_CLR, 32'h0000_0001);
        chk_eq("R9 back to single vector", single_vec, 1);
        bus_write(K_CTRL, 4'd0, O_SET, 32'h0000_0001);

        // R10: second reset clears populated state
        rst = 1; step(); rst = 0; step();
        read_chk("R10 flags cleared", K_FLAG, 4'd1, O_WR, 32'h0);
        read_chk("R10 enables cleared", K_EN, 4'd1, O_WR, 32'h0);
        read_chk("R10 levels cleared", K_LVL, 4'd1, O_WR, 32'h0);
        chk_eq("R10 mode cleared", single_vec, 1);
        chk_eq("R10 outputs cleared", win_level, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule